// File: doc/BRIEF.md
# Tagged Boot Record Loader

The loader takes a stream of 48-bit words and turns it into memory writes. The stream is a sequence of records. Each record opens with a tag word that names the kind of initialisation. Most tags are followed by a control word that gives a start address and a word count. An init record then carries exactly that many data words, and each one is written to the next address. A zero-fill record carries no data. For a zero-fill record the loader issues one zero write per cycle by itself, and holds its input not-ready until the region is filled.

The stream ends with a final tag. The word after it is a saved instruction, not a control word. Then 256 words follow, and the loader writes them over the boot region that starts at 0x40000. The last step is one extra write that places the saved instruction in the vector slot at 0x40038. After that the loader raises done. A tag that is malformed, unknown, or forbidden in this boot path raises error and freezes the loader until reset.

Each write goes out on a write port. Along with the address and data, the port carries a width code and a space code taken from the tag, so that the memory side can steer the write.

Top module: `boot_rec_loader`

## Requirements
- R1: After a synchronous active-low reset, in_ready is 1, and wr_en, error and done are 0.
- R2: A tag word carries the tag in bits 7:0. Bits 47:8 must be zero. A nonzero upper field, or a tag value above 0x1A, is rejected as in R7.
- R3: A control word carries the start address in bits 47:16 and the word count in bits 15:0. The tag and control words produce no write.
- R4: Init tags are 0x04-0x06, 0x0B-0x0E, 0x10, 0x12 and 0x13-0x15. For these, each of the next count accepted words is written in the cycle it is accepted, with wr_data equal to the word and wr_addr equal to the start address plus the word index.
- R5: Zero-fill tags are 0x01-0x03, 0x07-0x0A, 0x0F, 0x11 and 0x17-0x19. For these, starting in the cycle after the control word, the loader writes zero for count cycles in a row, at consecutive addresses, with in_ready at 0. In the cycle after that it is ready for the next tag.
- R6: A count of zero produces no write. The next accepted word is treated as a tag.
- R7: Tags 0x16 and 0x1A are rejected, and so is any word rejected under R2. In the cycle after the word is accepted, error rises. From then until reset, error stays at 1, in_ready stays at 0, and wr_en stays at 0.
- R8: The width code is 0=8, 1=16, 2=32, 3=40, 4=48 and 5=64 bits. The space code is 0=internal data, 1=internal program and 2=external. Both codes follow the tag: DM16/32/40/64 for 0x01-0x06, 0x0F and 0x10; PM16/32/40/48 for 0x07-0x0E; PM64 for 0x11 and 0x12; external 8/16/32 for 0x13-0x15 and 0x17-0x19.
- R9: After tag 0x00, the next accepted word is saved and not written. The 256 words after it are written to 0x40000+i, with width code 4 and space code 1.
- R10: In the cycle after the 256th final word, the saved word is written to 0x40038 with in_ready at 0. From the following cycle on, done is 1, wr_en is 0 and in_ready is 0.
- R11: While in_ready is 1 and in_valid is 0, no write occurs and the record does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream word is present |
| in_word | input | 48 | Stream word |
| in_ready | output | 1 | Loader takes the word this cycle |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Write address |
| wr_data | output | 48 | Write data |
| wr_width | output | 3 | Width code (R8) |
| wr_space | output | 2 | Space code (R8) |
| error | output | 1 | Sticky rejection flag |
| done | output | 1 | Stream complete |

## Verification
A record-state error shows at the ports within one accepted word. A data word that is taken as a control word, or the reverse, moves wr_en and wr_addr on the very next write. A wrong address or count register shows as an address that skips or stalls between two writes in a row, or as in_ready coming back one cycle early or late at the end of a fill. Faults in the final stage show either as a missing vector write at 0x40038, or as done rising before that write or never rising. These are the exact cycles the directed tests sample.

// File: rtl/boot_ldr_pkg.sv
// Shared types for the boot record loader: record kinds, width and space
// codes, and the tag decode function.
// Assumes the tag fits in 8 bits; anything not listed decodes as bad.
package boot_ldr_pkg;

    typedef enum logic [1:0] {K_BAD, K_FINAL, K_INIT, K_ZERO} rec_kind_e;
    typedef enum logic [2:0] {WC_8, WC_16, WC_32, WC_40, WC_48, WC_64} width_e;
    typedef enum logic [1:0] {SP_DATA, SP_PROG, SP_EXT} space_e;

    typedef struct packed {
        rec_kind_e kind;
        width_e    width;
        space_e    space;
    } tag_info_t;

    // Map one tag value to its record kind, width and target space.
    function automatic tag_info_t decode_tag(input logic [7:0] t);
        tag_info_t r;
        r = '{kind: K_BAD, width: WC_8, space: SP_DATA};
        case (t)
            8'h00: r = '{kind: K_FINAL, width: WC_48, space: SP_PROG};
            8'h01: r = '{kind: K_ZERO,  width: WC_16, space: SP_DATA};
            8'h02: r = '{kind: K_ZERO,  width: WC_32, space: SP_DATA};
            8'h03: r = '{kind: K_ZERO,  width: WC_40, space: SP_DATA};
            8'h04: r = '{kind: K_INIT,  width: WC_16, space: SP_DATA};
            8'h05: r = '{kind: K_INIT,  width: WC_32, space: SP_DATA};
            8'h06: r = '{kind: K_INIT,  width: WC_40, space: SP_DATA};
            8'h07: r = '{kind: K_ZERO,  width: WC_16, space: SP_PROG};
            8'h08: r = '{kind: K_ZERO,  width: WC_32, space: SP_PROG};
            8'h09: r = '{kind: K_ZERO,  width: WC_40, space: SP_PROG};
            8'h0A: r = '{kind: K_ZERO,  width: WC_48, space: SP_PROG};
            8'h0B: r = '{kind: K_INIT,  width: WC_16, space: SP_PROG};
            8'h0C: r = '{kind: K_INIT,  width: WC_32, space: SP_PROG};
            8'h0D: r = '{kind: K_INIT,  width: WC_40, space: SP_PROG};
            8'h0E: r = '{kind: K_INIT,  width: WC_48, space: SP_PROG};
            8'h0F: r = '{kind: K_ZERO,  width: WC_64, space: SP_DATA};
            8'h10: r = '{kind: K_INIT,  width: WC_64, space: SP_DATA};
            8'h11: r = '{kind: K_ZERO,  width: WC_64, space: SP_PROG};
            8'h12: r = '{kind: K_INIT,  width: WC_64, space: SP_PROG};
            8'h13: r = '{kind: K_INIT,  width: WC_8,  space: SP_EXT};
            8'h14: r = '{kind: K_INIT,  width: WC_16, space: SP_EXT};
            8'h15: r = '{kind: K_INIT,  width: WC_32, space: SP_EXT};
            8'h17: r = '{kind: K_ZERO,  width: WC_8,  space: SP_EXT};
            8'h18: r = '{kind: K_ZERO,  width: WC_16, space: SP_EXT};
            8'h19: r = '{kind: K_ZERO,  width: WC_32, space: SP_EXT};
            default: r = '{kind: K_BAD, width: WC_8, space: SP_DATA};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/boot_ldr_tag_dec.sv
// Tag word decoder: splits the tag field from a stream word and classifies it.
// Assumes the tag sits in the low TAG_W bits; any set bit above it makes the
// word bad, and so do the two 48-bit external tags (0x16, 0x1A).
module boot_ldr_tag_dec
    import boot_ldr_pkg::*;
#(
    parameter int WORD_W = 48,
    parameter int TAG_W  = 8
) (
    input  logic [WORD_W-1:0] word,
    output tag_info_t         info
);
    logic upper_clear;

    // Combine field check with table lookup.
    always_comb begin
        upper_clear = (word[WORD_W-1:TAG_W] == '0);
        info        = decode_tag(word[TAG_W-1:0]);
        if (!upper_clear) begin
            info.kind = K_BAD;
        end
    end
endmodule

// File: rtl/boot_ldr_walker.sv
// Address and remaining-count walker for one record region.
// Assumes load and step are never asserted together, and that step only
// comes while remaining is nonzero.
module boot_ldr_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [CNT_W-1:0] remaining;

    // Hold region pointer and words left; load wins, step advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= load_addr;
            remaining <= load_cnt;
        end else if (step) begin
            addr      <= addr + ADDR_W'(1);
            remaining <= remaining - CNT_W'(1);
        end
    end

    // Flag the final word of the region.
    always_comb last = (remaining == CNT_W'(1));

    // R4/R5: each step moves the pointer to the next address.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr == $past(addr) + ADDR_W'(1));

    // R5: a step never happens on an exhausted region.
    p_step_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> remaining != '0);
endmodule

// File: rtl/boot_rec_loader.sv
// Tagged boot record loader top: parses tag, control, data and final
// records from a 48-bit word stream and drives a memory write port.
// Assumes the consumer takes one write per cycle with no back-pressure.
module boot_rec_loader
    import boot_ldr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          CNT_W      = 16,
    parameter int          TAG_W      = 8,
    parameter int          FINAL_LEN  = 256,
    parameter logic [31:0] FINAL_BASE = 32'h0004_0000,
    parameter logic [31:0] VEC_ADDR   = 32'h0004_0038
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [ADDR_W+CNT_W-1:0] in_word,
    output logic                    in_ready,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [ADDR_W+CNT_W-1:0] wr_data,
    output logic [2:0]              wr_width,
    output logic [1:0]              wr_space,
    output logic                    error,
    output logic                    done
);
    localparam int WORD_W = ADDR_W + CNT_W;
    localparam logic [CNT_W-1:0]  FINAL_CNT = CNT_W'(FINAL_LEN);
    localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(FINAL_BASE);
    localparam logic [ADDR_W-1:0] VEC_A     = ADDR_W'(VEC_ADDR);

    typedef enum logic [3:0] {
        S_TAG, S_CTRL, S_DATA, S_FILL, S_FSAVE, S_FDATA, S_VEC, S_DONE, S_ERR
    } state_e;

    state_e            state, state_nx;
    tag_info_t         dec_info, cur_info;
    logic [WORD_W-1:0] saved_word;
    logic              accept;
    logic              w_load, w_step, w_last;
    logic [ADDR_W-1:0] w_addr, w_load_addr;
    logic [CNT_W-1:0]  w_load_cnt, ctl_cnt;
    logic [ADDR_W-1:0] ctl_addr;

    boot_ldr_tag_dec #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_dec (
        .word (in_word),
        .info (dec_info)
    );

    boot_ldr_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (w_load),
        .load_addr (w_load_addr),
        .load_cnt  (w_load_cnt),
        .step      (w_step),
        .addr      (w_addr),
        .last      (w_last)
    );

    // Ready only in states that consume stream words.
    always_comb begin
        in_ready = (state == S_TAG) || (state == S_CTRL) || (state == S_DATA) ||
                   (state == S_FSAVE) || (state == S_FDATA);
        accept   = in_valid && in_ready;
        ctl_addr = in_word[WORD_W-1:CNT_W];
        ctl_cnt  = in_word[CNT_W-1:0];
    end

    // Next-state and walker control for the record sequence.
    always_comb begin
        state_nx    = state;
        w_load      = 1'b0;
        w_step      = 1'b0;
        w_load_addr = ctl_addr;
        w_load_cnt  = ctl_cnt;
        case (state)
            S_TAG: if (accept) begin
                case (dec_info.kind)
                    K_BAD:   state_nx = S_ERR;
                    K_FINAL: state_nx = S_FSAVE;
                    default: state_nx = S_CTRL;
                endcase
            end
            S_CTRL: if (accept) begin
                w_load = 1'b1;
                if (ctl_cnt == '0)                 state_nx = S_TAG;
                else if (cur_info.kind == K_ZERO)  state_nx = S_FILL;
                else                               state_nx = S_DATA;
            end
            S_DATA: if (accept) begin
                w_step = 1'b1;
                if (w_last) state_nx = S_TAG;
            end
            S_FILL: begin
                w_step = 1'b1;
                if (w_last) state_nx = S_TAG;
            end
            S_FSAVE: if (accept) begin
                w_load      = 1'b1;
                w_load_addr = BASE_A;
                w_load_cnt  = FINAL_CNT;
                state_nx    = S_FDATA;
            end
            S_FDATA: if (accept) begin
                w_step = 1'b1;
                if (w_last) state_nx = S_VEC;
            end
            S_VEC:   state_nx = S_DONE;
            S_DONE:  state_nx = S_DONE;
            default: state_nx = S_ERR;
        endcase
    end

    // State, current tag attributes and saved final instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_TAG;
            cur_info   <= '{kind: K_BAD, width: WC_8, space: SP_DATA};
            saved_word <= '0;
        end else begin
            state <= state_nx;
            if (state == S_TAG && accept) cur_info <= dec_info;
            if (state == S_FSAVE && accept) saved_word <= in_word;
        end
    end

    // Drive the memory write port from the current state.
    always_comb begin
        wr_en    = ((state == S_DATA || state == S_FDATA) && in_valid) ||
                   (state == S_FILL) || (state == S_VEC);
        wr_addr  = (state == S_VEC) ? VEC_A : w_addr;
        wr_data  = (state == S_FILL) ? '0 :
                   (state == S_VEC)  ? saved_word : in_word;
        wr_width = cur_info.width;
        wr_space = cur_info.space;
        error    = (state == S_ERR);
        done     = (state == S_DONE);
    end

    // R7: rejection is sticky.
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    // R7: a stopped loader neither writes nor takes words.
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!wr_en && !in_ready));

    // R10: completion is sticky and silent.
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !wr_en));

    // R11: an idle input while ready produces no write.
    p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |-> !wr_en);

    // R10: done only follows the vector write.
    p_done_after_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(wr_en) && $past(wr_addr) == VEC_A));
endmodule

// File: tb/boot_rec_loader_test.sv
// Directed bench for the boot record loader; one task per scenario.
module boot_rec_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] in_word = '0;
    logic        in_ready, wr_en, error, done;
    logic [31:0] wr_addr;
    logic [47:0] wr_data;
    logic [2:0]  wr_width;
    logic [1:0]  wr_space;

    int n_checks = 0;
    int n_fail   = 0;

    logic        c_we, c_rdy;
    logic [31:0] c_addr;
    logic [47:0] c_data;
    logic [2:0]  c_w;
    logic [1:0]  c_s;

    always #4 clk = ~clk;

    boot_rec_loader uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_width(wr_width), .wr_space(wr_space),
        .error(error), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic capture();
        c_we = wr_en; c_rdy = in_ready; c_addr = wr_addr;
        c_data = wr_data; c_w = wr_width; c_s = wr_space;
    endtask

    // Offer one word; sample the port in the cycle it is taken.
    task automatic send(input logic [47:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1 capture();
        @(posedge clk);
    endtask

    // One idle cycle, sampled after the drive.
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        #1 capture();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ready", in_ready, 1);
        check("R1 wr_en", wr_en, 0);
        check("R1 error", error, 0);
        check("R1 done", done, 0);
    endtask

    function automatic logic [47:0] ctl(input logic [31:0] a, input logic [15:0] n);
        return {a, n};
    endfunction

    task automatic t_init();
        send(48'h05);
        check("R3 tag no write", c_we, 0);
        send(ctl(32'h1000, 16'd3));
        check("R3 ctrl no write", c_we, 0);
        for (int i = 0; i < 3; i++) begin
            send(48'hA000_0000_0000 + 48'(i));
            check("R4 we", c_we, 1);
            check("R4 addr", c_addr, 32'h1000 + 32'(i));
            check("R4 data", c_data, 48'hA000_0000_0000 + 48'(i));
        end
        check("R8 DM32 width", c_w, 2);
        check("R8 DM32 space", c_s, 0);
    endtask

    task automatic t_fill();
        send(48'h08);
        send(ctl(32'h2000, 16'd4));
        for (int i = 0; i < 4; i++) begin
            idle();
            check("R5 fill we", c_we, 1);
            check("R5 fill ready low", c_rdy, 0);
            check("R5 fill addr", c_addr, 32'h2000 + 32'(i));
            check("R5 fill data", c_data, 0);
        end
        check("R8 PM32 width", c_w, 2);
        check("R8 PM32 space", c_s, 1);
        idle();
        check("R5 ready after fill", c_rdy, 1);
        check("R5 no write after fill", c_we, 0);
    endtask

    task automatic t_zero_count();
        send(48'h04);
        send(ctl(32'h9999, 16'd0));
        send(48'h0B);
        check("R6 next word is tag", c_we, 0);
        send(ctl(32'h300, 16'd1));
        send(48'h1234);
        check("R6 record after zero count", c_addr, 32'h300);
        check("R8 PM16 width", c_w, 1);
        check("R8 PM16 space", c_s, 1);
    endtask

    task automatic t_stall();
        send(48'h0E);
        send(ctl(32'h400, 16'd2));
        send(48'h111);
        check("R11 first addr", c_addr, 32'h400);
        for (int i = 0; i < 3; i++) begin
            idle();
            check("R11 stall no write", c_we, 0);
            check("R11 stall ready", c_rdy, 1);
        end
        send(48'h222);
        check("R11 resume addr", c_addr, 32'h401);
        check("R11 resume data", c_data, 48'h222);
        check("R8 PM48 width", c_w, 4);
    endtask

    // One-word record of a given tag; check its codes.
    task automatic rec_one(input logic [7:0] tag, input logic [2:0] ew,
                           input logic [1:0] es, input logic is_zero);
        send(48'(tag));
        send(ctl(32'h5000, 16'd1));
        if (is_zero) idle(); else send(48'h77);
        check("R8 width", c_w, ew);
        check("R8 space", c_s, es);
        check("R8 write", c_we, 1);
    endtask

    task automatic t_final();
        logic [47:0] sv;
        int bad;
        sv  = 48'hABCD_1234_5678;
        bad = 0;
        send(48'h00);
        check("R9 final tag no write", c_we, 0);
        send(sv);
        check("R9 saved no write", c_we, 0);
        for (int i = 0; i < 256; i++) begin
            send(48'hF000_0000_0000 + 48'(i));
            if (!c_we || c_addr != 32'h40000 + 32'(i) ||
                c_data != 48'hF000_0000_0000 + 48'(i) || c_w != 3'd4 || c_s != 2'd1)
                bad++;
        end
        check("R9 final block writes", 64'(bad), 0);
        idle();
        check("R10 vec we", c_we, 1);
        check("R10 vec addr", c_addr, 32'h40038);
        check("R10 vec data", c_data, sv);
        check("R10 vec ready low", c_rdy, 0);
        check("R10 done not yet", done, 0);
        for (int i = 0; i < 3; i++) begin
            idle();
            check("R10 done", done, 1);
            check("R10 quiet", c_we, 0);
            check("R10 ready low", c_rdy, 0);
        end
    endtask

    task automatic t_reject(input logic [47:0] w, input string req);
        do_reset();
        send(w);
        check({req, " no write on tag"}, c_we, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = ctl(32'h10, 16'd2);
            #1;
            check({req, " error"}, error, 1);
            check({req, " ready low"}, in_ready, 0);
            check({req, " no write"}, wr_en, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        do_reset();
        t_init();
        t_fill();
        t_zero_count();
        t_stall();
        rec_one(8'h06, 3'd3, 2'd0, 1'b0);
        rec_one(8'h10, 3'd5, 2'd0, 1'b0);
        rec_one(8'h12, 3'd5, 2'd1, 1'b0);
        rec_one(8'h13, 3'd0, 2'd2, 1'b0);
        rec_one(8'h14, 3'd1, 2'd2, 1'b0);
        rec_one(8'h15, 3'd2, 2'd2, 1'b0);
        rec_one(8'h17, 3'd0, 2'd2, 1'b1);
        rec_one(8'h03, 3'd3, 2'd0, 1'b1);
        rec_one(8'h11, 3'd5, 2'd1, 1'b1);
        t_final();
        t_reject(48'h16, "R7 tag16");
        t_reject(48'h1A, "R7 tag1A");
        t_reject(48'h1B, "R2 unknown");
        t_reject(48'h0100_0000_0005, "R2 upper bits");
        do_reset();
        finish_run();
    end
endmodule